// File: doc/BRIEF.md
# PLL Control and Status Register

This block is one byte-wide register that sits on a simple 8-bit peripheral bus and steers a clock-generator PLL. It stores a PLL power switch, a base-clock select bit, a two-bit prescaler code and a two-bit VCO range code. Each of these drives an output pin straight to the clock generator.

The same byte also holds an interrupt enable and a lock-change flag. The PLL's lock indication arrives asynchronously. The block synchronizes it and sets the flag whenever lock is gained or lost. Software clears the flag by reading the register.

An external mode input comes from a separate bandwidth-control register. While it is low, the interrupt features are masked: the enable cannot be changed, and both the enable and the flag read as zero.

Top module: `pll_ctl_reg`

## Requirements
- R1: After reset the power-switch output is 1 and every other field is 0, so a read returns 0x20 and the interrupt request is low.
- R2: A read at the register address returns, in the same cycle, the enable in bit 7, the flag in bit 6, the power switch in bit 5, the base-clock select in bit 4, the prescaler in bits 3:2 and the VCO range in bits 1:0.
- R3: A write at the register address updates the power switch, the base-clock select, the prescaler and the VCO range from the same bit positions, and the outputs show the new values after the next clock edge.
- R4: A change of the lock input in either direction sets the flag three clock edges after the change is first sampled: two synchronizer stages plus one edge-detect stage.
- R5: Any read at the register address clears the flag at the next clock edge.
- R6: If a lock change is detected in the same cycle as a clearing read, the flag ends up set.
- R7: The interrupt request is high exactly while the enable and the flag both read as 1.
- R8: While the mode input is 0, writes to bit 7 leave the stored enable unchanged, and bit 7 reads as 0.
- R9: While the mode input is 0, bit 6 reads as 0 and the interrupt request is low. A lock change in this period is still recorded and becomes visible once the mode input returns to 1.
- R10: Bit 6 is read-only: writing 1 to it never sets the flag.
- R11: A write to any other address changes nothing, and a read of any other address returns 0 and leaves the flag untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| auto_mode | input | 1 | Bandwidth-control mode; gates enable and flag |
| lock_async | input | 1 | Asynchronous PLL lock indication |
| irq | output | 1 | Interrupt request |
| pll_on | output | 1 | PLL power switch |
| base_sel | output | 1 | Base-clock select |
| prescale | output | 2 | Prescaler code |
| vco_range | output | 2 | VCO range code |

## Verification
The bench builds the block with its defaults: an 8-bit address, the register at 0x36 and a two-stage synchronizer. At that depth the full lock-to-flag latency is three edges. This makes it possible to place a read exactly on the cycle where the edge detector fires, which exercises the race between setting and clearing. A behavioural model keeps a short history of sampled lock values, so it predicts the flag from the synchronizer depth and not from the circuit. Lock toggles while the mode input is low show that the flag is recorded even though it is masked on reads.

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              auto_mode,
  input  logic              lock_async,
  output logic              irq,
  output logic              pll_on,
  output logic              base_sel,
  output logic [1:0]        prescale,
  output logic [1:0]        vco_range
);
  localparam int B_IE  = 7;
  localparam int B_FLG = 6;
  localparam int B_ON  = 5;
  localparam int B_BCS = 4;
  localparam int B_PRE = 2;
  localparam int B_VPR = 0;

  logic [SYNC_STAGES-1:0] sync_q;
  logic lock_d, toggle;
  logic flag_q, ie_q;
  logic sel, rd_hit, wr_hit;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= lock_async;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lock_d <= 1'b0;
    else lock_d <= sync_q[SYNC_STAGES-1];

  assign toggle = sync_q[SYNC_STAGES-1] ^ lock_d;
  assign sel    = (bus_addr == REG_ADDR);
  assign rd_hit = sel & bus_rd;
  assign wr_hit = sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (toggle) flag_q <= 1'b1;
    else if (rd_hit) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      pll_on    <= 1'b1;
      base_sel  <= 1'b0;
      prescale  <= 2'b00;
      vco_range <= 2'b00;
    end else if (wr_hit) begin
      if (auto_mode) ie_q <= bus_wdata[B_IE];
      pll_on    <= bus_wdata[B_ON];
      base_sel  <= bus_wdata[B_BCS];
      prescale  <= bus_wdata[B_PRE +: 2];
      vco_range <= bus_wdata[B_VPR +: 2];
    end
  end

  logic ie_vis, flag_vis;
  assign ie_vis   = ie_q & auto_mode;
  assign flag_vis = flag_q & auto_mode;
  assign irq      = ie_vis & flag_vis;

  assign bus_rdata = rd_hit ? {ie_vis, flag_vis, pll_on, base_sel, prescale, vco_range} : 8'h00;

  p_set_on_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> flag_q);
  p_rise_needs_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(toggle));
  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !toggle) |=> !flag_q);
  p_race_keeps_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && toggle) |=> flag_q);
  p_irq_needs_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> auto_mode);
  p_ie_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |=> $stable(ie_q));
  p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable({pll_on, base_sel, prescale, vco_range}));
  p_other_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> bus_rdata == 8'h00);
endmodule

// File: tb/sim_pll_ctl_reg.sv
module sim_pll_ctl_reg;
  localparam int SYNC = 2;
  localparam logic [7:0] RA = 8'h36;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic bus_wr = 1'b0, bus_rd = 1'b0, auto_mode = 1'b1, lock_async = 1'b0;
  logic [7:0] bus_rdata;
  logic irq, pll_on, base_sel;
  logic [1:0] prescale, vco_range;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pll_ctl_reg #(.ADDR_W(8), .REG_ADDR(RA), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .auto_mode(auto_mode),
    .lock_async(lock_async), .irq(irq), .pll_on(pll_on), .base_sel(base_sel),
    .prescale(prescale), .vco_range(vco_range));

  // behavioural reference: history of sampled lock values
  bit hist[$];
  bit m_flag, m_ie, m_on, m_bcs;
  int m_pre, m_vpr;

  task automatic m_reset();
    hist = {};
    for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);
    m_flag = 0; m_ie = 0; m_on = 1; m_bcs = 0; m_pre = 0; m_vpr = 0;
  endtask

  initial m_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      bit tog, rd, wr;
      tog = hist[SYNC-1] != hist[SYNC];
      rd = (bus_addr == RA) && bus_rd;
      wr = (bus_addr == RA) && bus_wr;
      if (tog) m_flag = 1;
      else if (rd) m_flag = 0;
      if (wr) begin
        if (auto_mode) m_ie = bus_wdata[7];
        m_on = bus_wdata[5]; m_bcs = bus_wdata[4];
        m_pre = bus_wdata[3:2]; m_vpr = bus_wdata[1:0];
      end
      hist.push_front(lock_async);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] m_rdata();
    if (bus_addr != RA || !bus_rd) return 8'h00;
    return {m_ie & auto_mode, m_flag & auto_mode, m_on, m_bcs, 2'(m_pre), 2'(m_vpr)};
  endfunction

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic cyc();
    #1;
    chk("R2 rdata", bus_rdata, m_rdata());
    chk("R7 irq", irq, int'(m_ie & m_flag & auto_mode));
    chk("R3 ctl", {pll_on, base_sel, prescale, vco_range}, {m_on, m_bcs, 2'(m_pre), 2'(m_vpr)});
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    cyc();
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1;
    #1 v = bus_rdata;
    cyc();
    bus_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 pll_on", pll_on, 1);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    cyc();
    rd(RA, v); chk("R1 read", v, 8'h20);

    // R3 / R2 field writes
    wr(RA, 8'h0F);
    chk("R3 prescale", prescale, 3); chk("R3 vco_range", vco_range, 3); chk("R3 pll_on", pll_on, 0);
    rd(RA, v); chk("R2 layout", v, 8'h0F);
    wr(RA, 8'hF5); // bit 6 write ignored
    rd(RA, v); chk("R10 flag not writable", v, 8'hB5);
    wr(RA, 8'hA6);
    rd(RA, v); chk("R2 layout 2", v, 8'hA6);

    // R4 rising lock
    lock_async = 1;
    cyc(); cyc();
    chk("R4 not yet", irq, 0);
    cyc();
    chk("R4/R7 irq after rise", irq, 1);
    rd(RA, v); chk("R4 flag set rising", v, 8'hE6);
    rd(RA, v); chk("R5 flag cleared", v, 8'hA6);
    chk("R5 irq low", irq, 0);

    // R4 falling lock
    lock_async = 0;
    repeat (3) cyc();
    rd(RA, v); chk("R4 flag set falling", v, 8'hE6);

    // R6 race: read coincides with detected toggle
    lock_async = 1;
    cyc(); cyc();
    rd(RA, v);
    rd(RA, v); chk("R6 flag survives race", v[6], 1);

    // R11 other address
    wr(8'h37, 8'h00);
    chk("R11 write ignored", {pll_on, base_sel, prescale, vco_range}, 6'b100110);
    lock_async = 0; repeat (3) cyc();
    rd(8'h35, v); chk("R11 read other zero", v, 0);
    rd(RA, v); chk("R11 flag untouched", v[6], 1);

    // R8 / R9 mode low
    auto_mode = 0;
    wr(RA, 8'h26);
    rd(RA, v); chk("R8 enable reads zero", v[7], 0);
    lock_async = 1; repeat (3) cyc();
    chk("R9 irq masked", irq, 0);
    rd(RA, v); chk("R9 flag reads zero", v[6], 0);
    lock_async = 0; repeat (3) cyc();
    auto_mode = 1;
    cyc();
    chk("R9 flag recorded", irq, 1);
    rd(RA, v); chk("R8 enable kept", v, 8'hE6);

    // R1 reset mid-run
    rst_n = 0; #1;
    chk("R1 async reset", {pll_on, base_sel, prescale, vco_range}, 6'b100000);
    @(negedge clk); rst_n = 1;
    rd(RA, v); chk("R1 read after reset", v, 8'h20);

    repeat (4) cyc();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule